// File: doc/BRIEF.md
# Sampled Majority-Free Deglitch Filter

This block cleans up one asynchronous input line, such as an encoder phase, an index pulse or a plain digital input. It runs on a fast master clock and takes a sample of the line only when an internal strobe fires. The strobe fires once every 2, 4 or 8 master-clock cycles, as a two-bit rate code selects. With a 16 MHz master clock these rates are 8, 4 and 2 MHz. The filtered output moves to a new level only after three strobed samples in a row have all shown that level. A short spike therefore never reaches the logic that follows.

There are four storage stages in the line. The first one retimes the raw input on every master-clock edge. The other three hold the most recent strobed samples. Whenever these three samples agree, the output takes their value on the next clock edge. When they disagree, the output keeps its previous value. Each input line that needs filtering gets its own instance. A lower sample rate rejects wider glitches, but it also limits how fast a real signal can toggle and still be seen.

Top module: `sample_deglitch`

## Requirements
- R1: While `rst` is high, and after it is released with `din` held low, `dout` is 0.
- R2: Rate code 2'b00 takes a sample every 2 clock cycles, 2'b01 every 4 and 2'b10 every 8. This is the divisor D in the requirements below.
- R3: Rate code 2'b11 behaves exactly like 2'b10, with D = 8.
- R4: A pulse of the opposite level that lasts at most 2·D clock cycles never appears on `dout`. This holds for both polarities.
- R5: A pulse that lasts at least 3·D clock cycles always appears on `dout`. Once the input returns to its base level and stays there, `dout` also returns to that level.
- R6: After a steady level change on `din`, `dout` follows after at least 2·D+3 and at most 3·D+2 rising clock edges. The count starts with the first edge after the change.
- R7: `dout` changes only when the last three strobed samples all equal the new level. The change happens exactly two cycles after a strobe. As a result, an input that toggles every D or every 2·D cycles leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Sample rate code (00: /2, 01: /4, 10 and 11: /8) |
| din | input | 1 | Raw asynchronous input line |
| dout | output | 1 | Filtered output level |

## Verification
Some behaviour is checked by assertions on every cycle:
- The sample strobe keeps an exact spacing for the selected rate, and it never lasts two cycles.
- `dout` changes only two cycles after a strobe, and only when the three preceding samples all agree with the new level.
- `dout` is 0 after reset.

Other behaviour only shows up in the bench scenarios, which start each pulse at every possible strobe phase:
- The rejection and acceptance bounds on pulse width, for both polarities and every rate code.
- The minimum and maximum latency to the output.
- The fallback of the reserved code.
- Rejection of sustained toggling.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

    typedef enum logic [1:0] {
        RATE_FAST = 2'b00,
        RATE_MID  = 2'b01,
        RATE_SLOW = 2'b10,
        RATE_RSVD = 2'b11
    } rate_sel_e;

    // Strobe divisor for a rate code; the reserved code uses the slowest rate.
    function automatic int unsigned rate_divisor(rate_sel_e code, int unsigned base);
        case (code)
            RATE_FAST: return base;
            RATE_MID:  return base * 2;
            default:   return base * 4;
        endcase
    endfunction

endpackage

// File: rtl/deglitch_rate_gen.sv
module deglitch_rate_gen
    import deglitch_pkg::*;
#(
    parameter int unsigned BASE_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       samp_en
);

    localparam int unsigned MAX_DIV = BASE_DIV * 4;
    localparam int unsigned CNT_W   = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(rate_divisor(rate_sel_e'(rate_sel), BASE_DIV) - 1);
    end

    // Wrap on >= so a switch to a faster rate never strands the counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            samp_en <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q   <= '0;
            samp_en <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            samp_en <= 1'b0;
        end
    end

endmodule

// File: rtl/deglitch_core.sv
module deglitch_core #(
    parameter int unsigned TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic din,
    output logic dout
);

    logic            sync_q;
    logic [TAPS-1:0] taps_q;
    logic            agree_hi;
    logic            agree_lo;

    always_comb begin
        agree_hi = &taps_q;
        agree_lo = ~|taps_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            taps_q <= '0;
            dout   <= 1'b0;
        end else begin
            sync_q <= din;
            if (samp_en) begin
                taps_q <= {taps_q[TAPS-2:0], sync_q};
            end
            if (agree_hi) begin
                dout <= 1'b1;
            end else if (agree_lo) begin
                dout <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sample_deglitch.sv
module sample_deglitch #(
    parameter int unsigned BASE_DIV = 2,
    parameter int unsigned TAPS     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    input  logic       din,
    output logic       dout
);

    logic samp_en;

    deglitch_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .rate_sel(rate_sel),
        .samp_en (samp_en)
    );

    deglitch_core #(.TAPS(TAPS)) u_core (
        .clk    (clk),
        .rst    (rst),
        .samp_en(samp_en),
        .din    (din),
        .dout   (dout)
    );

endmodule

// File: rtl/deglitch_checker.sv
module deglitch_checker
    import deglitch_pkg::*;
#(
    parameter int unsigned BASE_DIV = 2,
    parameter int unsigned TAPS     = 3
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] rate_sel,
    input logic       samp_en,
    input logic       sync_q,
    input logic       dout
);

    localparam int unsigned GAP_W = $clog2(BASE_DIV * 4) + 1;

    logic [GAP_W-1:0] gap_q;
    logic [1:0]       rate_q;
    logic             quiet_q;
    logic             seen_q;
    logic [TAPS-1:0]  hist_q;
    logic [GAP_W-1:0] exp_gap;

    always_comb begin
        exp_gap = GAP_W'(rate_divisor(rate_sel_e'(rate_q), BASE_DIV) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            rate_q  <= rate_sel;
            quiet_q <= 1'b0;
            seen_q  <= 1'b0;
            hist_q  <= '0;
        end else begin
            rate_q <= rate_sel;
            if (samp_en) begin
                gap_q   <= '0;
                seen_q  <= 1'b1;
                quiet_q <= (rate_sel == rate_q);
                hist_q  <= {hist_q[TAPS-2:0], sync_q};
            end else begin
                if (gap_q != '1) gap_q <= gap_q + 1'b1;
                if (rate_sel != rate_q) quiet_q <= 1'b0;
            end
        end
    end

    // R1: output cleared by reset
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !dout);

    // R2: strobe spacing matches the selected divisor
    a_r2_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        (samp_en && seen_q && quiet_q && rate_sel == rate_q) |-> gap_q == exp_gap);

    // R2: strobe is a single-cycle pulse
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        samp_en |=> !samp_en);

    // R7: output moves only two cycles after a strobe
    a_r7_change_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> $past(samp_en, 2));

    // R7: output moves only to a level all three samples agree on
    a_r7_three_agree: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> ($past(hist_q) == {TAPS{dout}}));

endmodule

bind sample_deglitch deglitch_checker #(.BASE_DIV(BASE_DIV), .TAPS(TAPS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rate_sel(rate_sel),
    .samp_en (samp_en),
    .sync_q  (u_core.sync_q),
    .dout    (dout)
);

// File: tb/test_sample_deglitch.sv
module test_sample_deglitch;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic       din = 1'b0;
    logic       dout;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sample_deglitch i_sample_deglitch (
        .clk     (clk),
        .rst     (rst),
        .rate_sel(rate_sel),
        .din     (din),
        .dout    (dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input logic lvl, input int d);
        @(negedge clk);
        din = lvl;
        repeat (4 * d + 6) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst = 1'b1;
        rate_sel = code;
        din = 1'b0;
        repeat (3) @(negedge clk);
        check(dout == 1'b0, "R1 during reset", dout, 0);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        check(dout == 1'b0, "R1 after release", dout, 0);
    endtask

    // Latency in rising edges from a level change to the output following
    task automatic latency(input logic lvl, input int d, input string tag);
        int n;
        @(negedge clk);
        din = lvl;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (dout != lvl && n <= 4 * d + 4);
        check(n >= 2 * d + 3 && n <= 3 * d + 2, tag, n, 3 * d + 2);
    endtask

    task automatic pulse_trial(input logic base, input int p, input int ph, input int d, input string tag);
        bit seen;
        settle(base, d);
        repeat (ph) @(negedge clk);
        din = ~base;
        repeat (p) @(negedge clk);
        din = base;
        seen = 1'b0;
        repeat (4 * d + 6) begin
            @(negedge clk);
            if (dout != base) seen = 1'b1;
        end
        if (p <= 2 * d) begin
            check(!seen, {tag, " R4 short pulse rejected"}, seen, 0);
        end else if (p >= 3 * d) begin
            check(seen, {tag, " R5 long pulse passed"}, seen, 1);
            check(dout == base, {tag, " R5 return to base"}, dout, base);
        end
    endtask

    task automatic toggle_trial(input int half, input int d, input string tag);
        bit seen;
        settle(1'b0, d);
        seen = 1'b0;
        for (int k = 0; k < 24; k++) begin
            din = ~din;
            repeat (half) begin
                @(negedge clk);
                if (dout) seen = 1'b1;
            end
        end
        check(!seen, {tag, " R7 toggling rejected"}, seen, 0);
    endtask

    initial begin
        for (int code = 0; code < 4; code++) begin
            int d;
            int nph;
            string tag;
            d   = (code == 0) ? 2 : (code == 1) ? 4 : 8;
            nph = (code == 3) ? 2 : d;
            tag = (code == 3) ? "R3" : "R2";
            do_reset(2'(code));
            latency(1'b1, d, {tag, " R6 rise latency"});
            latency(1'b0, d, {tag, " R6 fall latency"});
            for (int ph = 0; ph < nph; ph++) begin
                for (int p = 1; p <= 4 * d; p++) begin
                    pulse_trial(1'b0, p, ph, d, tag);
                    pulse_trial(1'b1, p, ph, d, tag);
                end
            end
            toggle_trial(d, d, tag);
            toggle_trial(2 * d, d, tag);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule